// File: doc/BRIEF.md
# Low-Transition Pseudo-Random Test Pattern Generator

This block supplies built-in self-test stimulus with fewer bit flips between successive vectors than a plain shift-register generator produces. A maximal-length Fibonacci LFSR walks through its primary sequence. Between two primary vectors the block emits a bridge vector. The bridge keeps every bit on which the two primaries agree. Every bit on which they disagree is replaced by a pseudo-random bit taken from one half of the LFSR register. Each step across a changing bit therefore splits into two smaller steps, and switching in the circuit under test drops while the primary sequence stays intact.

The generator emits one vector per enabled clock on a parallel output with a one-cycle valid strobe. A seed port restarts the sequence from any non-zero value. A zero seed is replaced with a built-in constant. Dropping the enable freezes all state and holds the output.

Top module: `lowtrans_tpg`

## Requirements
- R1: While reset is asserted and just after it is released, `vec_valid` is 0 and `vec_out` is all zeros. The first vector emitted after reset is `SEED_DEFAULT` (default 16'hACE1).
- R2: The primary successor of state s is {s[N-2:0], ^(s & TAPS)}. The default TAPS value 16'hB400 selects bits 15, 13, 12 and 10.
- R3: Emission order is P1, B1, P2, B2, P3 and so on. The LFSR moves from P(k) to P(k+1) only in the cycle that emits bridge B(k), so inserting bridges leaves the primary sequence unchanged.
- R4: Any bit on which P(k) and P(k+1) agree takes that common value in B(k).
- R5: A bit i on which P(k) and P(k+1) differ takes bit (i mod N/2) of the selected half of P(k) in B(k). The lower half is P(k)[N/2-1:0] and the upper half is P(k)[N-1:N/2].
- R6: The selected half starts as the lower half after reset or a seed load, and toggles after every bridge that is emitted.
- R7: A cycle with `seed_load` high takes effect whatever the level of `enable`. It loads `seed_value`, or `SEED_DEFAULT` when `seed_value` is zero, as the next primary vector. It clears the phase and the half selection. It gives `vec_valid` = 0 for that cycle and holds `vec_out`.
- R8: In a cycle with `enable` low and no load, `vec_valid` is 0, `vec_out` holds, and the sequence later resumes exactly where it stopped.
- R9: Every cycle with `enable` high and no load emits exactly one vector, and `vec_valid` is high for exactly that cycle.
- R10: The Hamming distance from a bridge to either of its neighbouring primaries never exceeds the distance between those primaries, and every bridge bit equals the matching bit of one of the two neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Emit one vector this cycle |
| seed_load | input | 1 | Restart the sequence from `seed_value` |
| seed_value | input | N | Seed. Zero selects `SEED_DEFAULT` |
| vec_out | output | N | Registered test vector |
| vec_valid | output | 1 | High for the cycle after a vector is emitted |

## Verification
The hardest situations to reach are a seed load that lands in the cycle a bridge is due, and an enable gap that splits a primary from its bridge. The stimulus covers both. It loads seeds while the bench model expects a bridge, and it drives irregular enable patterns, so the halted phase and the half selection must survive the gap. A behavioural model predicts every output cycle. A separate neighbour check tests every bridge against both primaries for bit membership and for Hamming distance.

// File: rtl/lowtrans_tpg_pkg.sv
package lowtrans_tpg_pkg;
  typedef enum logic {
    PH_PRIMARY = 1'b0,
    PH_BRIDGE  = 1'b1
  } ltp_phase_e;
endpackage

// File: rtl/ltp_lfsr.sv
module ltp_lfsr #(
  parameter int          N            = 16,
  parameter logic [N-1:0] TAPS        = 16'hB400,
  parameter logic [N-1:0] SEED_DEFAULT = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] seed_i,
  input  logic         advance_i,
  output logic [N-1:0] state_o,
  output logic [N-1:0] next_o
);
  logic [N-1:0] state_q;
  logic [N-1:0] state_d;
  logic         feedback;

  assign feedback = ^(state_q & TAPS);
  assign next_o   = {state_q[N-2:0], feedback};
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = (seed_i == '0) ? SEED_DEFAULT : seed_i;
    end else if (advance_i) begin
      state_d = next_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_DEFAULT;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/ltp_mixer.sv
module ltp_mixer #(
  parameter int N = 16
) (
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] nxt_i,
  input  logic         half_hi_i,
  output logic [N-1:0] bridge_o,
  output logic         change_any_o
);
  localparam int HALF = N / 2;

  logic [N-1:0]    change;
  logic [HALF-1:0] src_half;

  assign change       = cur_i ^ nxt_i;
  assign change_any_o = |change;
  assign src_half     = half_hi_i ? cur_i[N-1:HALF] : cur_i[HALF-1:0];

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int SRC = i % HALF;
    assign bridge_o[i] = change[i] ? src_half[SRC] : cur_i[i];
  end
endmodule

// File: rtl/ltp_sequencer.sv
module ltp_sequencer
  import lowtrans_tpg_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable_i,
  input  logic         load_i,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] bridge_i,
  input  logic         change_any_i,
  output logic         advance_o,
  output logic         half_hi_o,
  output logic         in_bridge_o,
  output logic [N-1:0] vec_o,
  output logic         valid_o
);
  ltp_phase_e   phase_q, phase_d;
  logic         half_q, half_d;
  logic [N-1:0] vec_q, vec_d;
  logic         valid_q, valid_d;

  always_comb begin
    phase_d   = phase_q;
    half_d    = half_q;
    vec_d     = vec_q;
    valid_d   = 1'b0;
    advance_o = 1'b0;
    if (load_i) begin
      phase_d = PH_PRIMARY;
      half_d  = 1'b0;
    end else if (enable_i) begin
      valid_d = 1'b1;
      if (phase_q == PH_PRIMARY) begin
        vec_d = cur_i;
        if (change_any_i) begin
          phase_d = PH_BRIDGE;
        end else begin
          advance_o = 1'b1;
        end
      end else begin
        vec_d     = bridge_i;
        advance_o = 1'b1;
        half_d    = ~half_q;
        phase_d   = PH_PRIMARY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRIMARY;
      half_q  <= 1'b0;
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      half_q  <= half_d;
      vec_q   <= vec_d;
      valid_q <= valid_d;
    end
  end

  assign half_hi_o   = half_q;
  assign in_bridge_o = (phase_q == PH_BRIDGE);
  assign vec_o       = vec_q;
  assign valid_o     = valid_q;
endmodule

// File: rtl/lowtrans_tpg.sv
module lowtrans_tpg #(
  parameter int           N            = 16,
  parameter logic [N-1:0] TAPS         = 16'hB400,
  parameter logic [N-1:0] SEED_DEFAULT = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         seed_load,
  input  logic [N-1:0] seed_value,
  output logic [N-1:0] vec_out,
  output logic         vec_valid
);
  logic [N-1:0] cur_vec;
  logic [N-1:0] nxt_vec;
  logic [N-1:0] bridge_vec;
  logic         change_any;
  logic         advance;
  logic         half_hi;
  logic         in_bridge;

  ltp_lfsr #(
    .N(N), .TAPS(TAPS), .SEED_DEFAULT(SEED_DEFAULT)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load_i(seed_load), .seed_i(seed_value),
    .advance_i(advance), .state_o(cur_vec), .next_o(nxt_vec)
  );

  ltp_mixer #(.N(N)) u_mixer (
    .cur_i(cur_vec), .nxt_i(nxt_vec), .half_hi_i(half_hi),
    .bridge_o(bridge_vec), .change_any_o(change_any)
  );

  ltp_sequencer #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .load_i(seed_load),
    .cur_i(cur_vec), .bridge_i(bridge_vec), .change_any_i(change_any),
    .advance_o(advance), .half_hi_o(half_hi), .in_bridge_o(in_bridge),
    .vec_o(vec_out), .valid_o(vec_valid)
  );
endmodule

// File: rtl/lowtrans_tpg_chk.sv
module lowtrans_tpg_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         seed_load,
  input logic [N-1:0] vec_out,
  input logic         vec_valid,
  input logic [N-1:0] cur_vec,
  input logic [N-1:0] nxt_vec,
  input logic         in_bridge,
  input logic         half_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (vec_valid == 1'b0 && vec_out == '0);
    end
  end

  p_primary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_bridge && enable && !seed_load) |=> (vec_out == $past(cur_vec)));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bridge && enable && !seed_load) |=> (cur_vec == $past(nxt_vec)));

  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bridge && enable && !seed_load) |=>
      (((vec_out ^ $past(cur_vec)) & ~($past(cur_vec) ^ $past(nxt_vec))) == '0));

  p_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bridge && enable && !seed_load) |=> (half_hi != $past(half_hi)));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (!vec_valid && !in_bridge && !half_hi && cur_vec != '0
                   && $stable(vec_out)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !seed_load) |=> (!vec_valid && $stable(vec_out)
                                 && $stable(cur_vec)));

  p_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !seed_load) |=> vec_valid);

  p_dist_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bridge && enable && !seed_load) |=>
      ($countones(vec_out ^ $past(cur_vec)) <= $countones($past(cur_vec) ^ $past(nxt_vec))));
endmodule

bind lowtrans_tpg lowtrans_tpg_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .seed_load(seed_load),
  .vec_out(vec_out), .vec_valid(vec_valid), .cur_vec(cur_vec),
  .nxt_vec(nxt_vec), .in_bridge(in_bridge), .half_hi(half_hi)
);

// File: tb/test_lowtrans_tpg.sv
`timescale 1ns/1ps
module test_lowtrans_tpg;
  localparam int          N    = 16;
  localparam int          H    = N / 2;
  localparam logic [N-1:0] DEF = 16'hACE1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable;
  logic         seed_load;
  logic [N-1:0] seed_value;
  logic [N-1:0] vec_out;
  logic         vec_valid;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  lowtrans_tpg i_lowtrans_tpg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .seed_load(seed_load),
    .seed_value(seed_value), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: taps 15,13,12,10 feed bit 0 on a left shift (R2)
  function automatic logic [N-1:0] step(input logic [N-1:0] s);
    int tap[4] = '{15, 13, 12, 10};
    logic fb = 1'b0;
    foreach (tap[k]) fb ^= s[tap[k]];
    return {s[N-2:0], fb};
  endfunction

  logic [N-1:0] m_cur;
  logic         m_bridge_next;
  logic         m_half;
  logic [N-1:0] exp_out;
  logic         exp_valid;
  int           exp_kind;   // 0 idle, 1 primary, 2 bridge, 3 load

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = DEF; m_bridge_next = 1'b0; m_half = 1'b0;
      exp_out = '0; exp_valid = 1'b0; exp_kind = 0;
    end else if (seed_load) begin
      m_cur = (seed_value == '0) ? DEF : seed_value;   // R7
      m_bridge_next = 1'b0; m_half = 1'b0; exp_valid = 1'b0; exp_kind = 3;
    end else if (enable) begin
      logic [N-1:0] nx;
      nx = step(m_cur);
      exp_valid = 1'b1;
      if (!m_bridge_next) begin
        exp_out = m_cur; exp_kind = 1;
        if (nx != m_cur) m_bridge_next = 1'b1; else m_cur = nx;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (m_cur[i] != nx[i])
            exp_out[i] = m_half ? m_cur[H + (i % H)] : m_cur[i % H];  // R5
          else
            exp_out[i] = m_cur[i];                                    // R4
        end
        exp_kind = 2;
        m_cur = nx; m_half = ~m_half;  // R6 alternation, R3 advance
        m_bridge_next = 1'b0;
      end
    end else begin
      exp_valid = 1'b0; exp_kind = 0;  // R8
    end
  end

  // Per-cycle comparison plus the neighbour test on every bridge
  bit           run_cmp = 1'b0;
  bit           have_prim = 1'b0;
  bit           have_br = 1'b0;
  logic [N-1:0] last_prim;
  logic [N-1:0] br_v;

  always @(negedge clk) begin
    if (run_cmp) begin
      check(vec_valid == exp_valid, "R9 valid", {15'd0, vec_valid}, {15'd0, exp_valid});
      check(vec_out == exp_out, (exp_kind == 2) ? "R5 bridge" : "R2 primary/R8 hold",
            vec_out, exp_out);
      if (exp_kind == 3) begin
        have_prim = 1'b0; have_br = 1'b0;
      end else if (exp_kind == 2 && vec_valid) begin
        br_v = vec_out; have_br = have_prim;
      end else if (exp_kind == 1 && vec_valid) begin
        if (have_br) begin
          logic [N-1:0] ok_bits;
          ok_bits = ~((br_v ^ last_prim) & (br_v ^ vec_out));
          check(ok_bits == '1, "R10 bridge bits from neighbours", br_v, last_prim);
          check($countones(br_v ^ last_prim) <= $countones(last_prim ^ vec_out) &&
                $countones(br_v ^ vec_out) <= $countones(last_prim ^ vec_out),
                "R10 Hamming bound", br_v, vec_out);
        end
        last_prim = vec_out; have_prim = 1'b1; have_br = 1'b0;
      end
    end
  end

  task automatic cycles(input int n, input bit en);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      enable = en;
    end
  endtask

  task automatic load(input logic [N-1:0] v, input bit en);
    @(negedge clk);
    seed_load = 1'b1; seed_value = v; enable = en;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; seed_load = 1'b0; seed_value = '0;
    repeat (3) @(negedge clk);
    check(vec_valid == 1'b0 && vec_out == '0, "R1 reset state", vec_out, '0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(vec_valid && vec_out == DEF, "R1 first vector", vec_out, DEF);
    cycles(60, 1'b1);
    // irregular enable gaps (R8), including gaps between primary and bridge
    for (int r = 0; r < 40; r++) begin
      @(negedge clk);
      enable = ((r % 3) == 0) || ((r % 7) == 2);
    end
    cycles(1, 1'b0);
    begin
      logic [N-1:0] held;
      held = vec_out;
      cycles(4, 1'b0);
      check(vec_out == held && !vec_valid, "R8 output holds", vec_out, held);
    end
    // zero seed with enable high (R7)
    load('0, 1'b1);
    @(negedge clk);
    check(vec_valid && vec_out == DEF, "R7 zero seed replaced", vec_out, DEF);
    cycles(11, 1'b1);
    // non-zero seed while disabled, landing where a bridge was due (R7)
    load(16'h8001, 1'b0);
    enable = 1'b1;
    @(negedge clk);
    check(vec_valid && vec_out == 16'h8001, "R7 seed loads", vec_out, 16'h8001);
    load(16'hFFFF, 1'b1);
    cycles(30, 1'b1);
    load(16'h0F0F, 1'b1);
    cycles(2000, 1'b1);
    for (int r = 0; r < 300; r++) begin
      @(negedge clk);
      enable = (r % 5) != 4;
    end
    enable = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule